// File: doc/BRIEF.md
# Programmable I/O Chip-Select Comparator

This block drives the chip selects of four peripherals on an 8-bit I/O bus: a counter/timer, a dual UART and two parallel I/O ports. Each select is asserted by comparing the I/O address against a base value held in a register. The host can reload these registers at run time, so a different firmware I/O map needs no change to the logic. Each peripheral compares only the address bits it does not use internally for its own register selection. The counter/timer compares all eight bits. The UART and both parallel ports each compare the upper six bits.

A select is active only during a true I/O cycle: the I/O request strobe is low and the opcode-fetch strobe is high. Interrupt-acknowledge cycles therefore never select a peripheral. Each base register carries an enable bit. When two or more enabled windows claim the same address, a fixed priority picks one winner, and a clash output reports the conflict for as long as it lasts.

Top module: `iosel_top`

## Requirements
- R1: After reset, the configuration holds these enabled windows: counter/timer base 0x10, UART base 0x00, parallel port 0 base 0x04, parallel port 1 base 0x08. No two of them overlap.
- R2: The counter/timer select (`tmr_sel_n`) goes low only when all eight address bits equal its base.
- R3: The UART select (`uart_sel_n`) goes low when address bits 7..2 equal its base bits 7..2, whatever the value of address bits 1..0.
- R4: Each parallel port select (`pio0_sel_n`, `pio1_sel_n`) goes low when address bits 7..2 equal its base bits 7..2, whatever the value of address bits 1..0.
- R5: A write with `cfg_we` high at a rising clock edge loads `cfg_wdata` into channel `cfg_idx`, and the selects use the new value from that edge on. The index encoding is 0 = counter/timer, 1 = UART, 2 = parallel port 0, 3 = parallel port 1. The data fields are bit 8 = enable and bits 7..0 = base.
- R6: All selects stay high unless `iorq_n` is low and `m1_n` is high.
- R7: A channel whose enable bit is clear never asserts its select.
- R8: At most one select is low at a time. When several enabled windows match, the winner follows the order counter/timer, then UART, then parallel port 0, then parallel port 1.
- R9: `clash` is high exactly when, during a qualified I/O cycle, two or more enabled windows match the address.
- R10: While `cfg_we` is low, `cfg_idx` and `cfg_wdata` leave the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset; loads the default windows |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Channel addressed by a configuration write |
| cfg_wdata | input | 9 | Enable bit (8) and base address (7..0) |
| iorq_n | input | 1 | Active-low I/O request strobe |
| m1_n | input | 1 | Active-low opcode-fetch strobe; low together with `iorq_n` marks an interrupt acknowledge |
| addr | input | 8 | Low byte of the I/O address |
| tmr_sel_n | output | 1 | Active-low counter/timer select |
| uart_sel_n | output | 1 | Active-low dual UART select |
| pio0_sel_n | output | 1 | Active-low parallel port 0 select |
| pio1_sel_n | output | 1 | Active-low parallel port 1 select |
| clash | output | 1 | High while more than one enabled window matches a qualified cycle |

## Verification
The only state in this block is the configuration bank, so a corrupted base or enable bit cannot hide for long. It shows on the first qualified I/O cycle that touches the affected window: either the select fails to drop at an address that should hit, or it drops at an address that should miss. Both effects appear in the same cycle, because the selects are combinational from the address. Faults in the arbitration show only when windows overlap, so the bench builds overlaps on purpose. It checks which select wins and whether `clash` rises.

// File: rtl/iosel_pkg.sv
package iosel_pkg;

   // Channel numbering; the order is also the priority order (lowest wins).
   typedef enum logic [1:0] {
      CH_TMR  = 2'd0,
      CH_UART = 2'd1,
      CH_PIO0 = 2'd2,
      CH_PIO1 = 2'd3
   } iosel_chan_e;

   localparam int unsigned IOSEL_NUM_CH = 4;

   // Mask that keeps the bits a window compares.
   function automatic logic [63:0] iosel_keep_mask(input int unsigned skip);
      logic [63:0] m;
      m = '1;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i < skip) m[i] = 1'b0;
      end
      return m;
   endfunction

endpackage

// File: rtl/iosel_cfg_bank.sv
module iosel_cfg_bank #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CFG_W  = 9,
   parameter logic [NUM_CH-1:0][CFG_W-1:0] RST_CFG = '0,
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IDX_W-1:0]              idx,
   input  logic [CFG_W-1:0]              wdata,
   output logic [NUM_CH-1:0][CFG_W-1:0]  cfg_q
);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      logic hit_slot;
      assign hit_slot = we && (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[g] <= RST_CFG[g];
         end else if (hit_slot) begin
            cfg_q[g] <= wdata;
         end
      end
   end

endmodule

// File: rtl/iosel_window_cmp.sv
module iosel_window_cmp #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned SKIP   = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic              en,
   input  logic              qual,
   output logic              hit
);
   import iosel_pkg::*;

   localparam logic [ADDR_W-1:0] KEEP = ADDR_W'(iosel_keep_mask(SKIP));

   logic match;

   if (SKIP >= ADDR_W) begin : g_bad
      $error("iosel_window_cmp: SKIP must be below ADDR_W");
   end

   if (SKIP == 0) begin : g_exact
      assign match = (addr == base);
   end else begin : g_masked
      assign match = ((addr ^ base) & KEEP) == '0;
   end

   assign hit = qual && en && match;

endmodule

// File: rtl/iosel_arbiter.sv
module iosel_arbiter #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] hit,
   output logic [NUM_CH-1:0] grant,
   output logic              multi
);

   if (NUM_CH < 2) begin : g_bad
      $error("iosel_arbiter: NUM_CH must be at least 2");
   end

   always_comb begin
      logic seen;
      logic twice;
      seen  = 1'b0;
      twice = 1'b0;
      grant = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (hit[i]) begin
            if (seen) twice = 1'b1;
            else      grant[i] = 1'b1;
            seen = 1'b1;
         end
      end
      multi = twice;
   end

endmodule

// File: rtl/iosel_top.sv
module iosel_top #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned TMR_SKIP  = 0,
   parameter int unsigned UART_SKIP = 2,
   parameter int unsigned PIO_SKIP  = 2,
   parameter logic [ADDR_W-1:0] TMR_RST  = 8'h10,
   parameter logic [ADDR_W-1:0] UART_RST = 8'h00,
   parameter logic [ADDR_W-1:0] PIO0_RST = 8'h04,
   parameter logic [ADDR_W-1:0] PIO1_RST = 8'h08,
   localparam int unsigned NUM_CH = iosel_pkg::IOSEL_NUM_CH,
   localparam int unsigned CFG_W  = ADDR_W + 1,
   localparam int unsigned IDX_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              iorq_n,
   input  logic              m1_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              tmr_sel_n,
   output logic              uart_sel_n,
   output logic              pio0_sel_n,
   output logic              pio1_sel_n,
   output logic              clash
);
   import iosel_pkg::*;

   localparam logic [NUM_CH-1:0][CFG_W-1:0] RST_CFG =
      {{1'b1, PIO1_RST}, {1'b1, PIO0_RST}, {1'b1, UART_RST}, {1'b1, TMR_RST}};

   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_w
      $error("iosel_top: ADDR_W out of range");
   end
   if (UART_SKIP >= ADDR_W || PIO_SKIP >= ADDR_W || TMR_SKIP >= ADDR_W) begin : g_bad_skip
      $error("iosel_top: a window skips every address bit");
   end

   logic [NUM_CH-1:0][CFG_W-1:0] cfg_q;
   logic [NUM_CH-1:0]            hit;
   logic [NUM_CH-1:0]            grant;
   logic                         io_cycle;

   // An I/O cycle without the fetch strobe; interrupt acknowledge is excluded.
   assign io_cycle = !iorq_n && m1_n;

   iosel_cfg_bank #(
      .NUM_CH (NUM_CH),
      .CFG_W  (CFG_W),
      .RST_CFG(RST_CFG)
   ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (cfg_we),
      .idx  (cfg_idx),
      .wdata(cfg_wdata),
      .cfg_q(cfg_q)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_win
      localparam int unsigned SKIP = (g == int'(CH_TMR))  ? TMR_SKIP  :
                                     (g == int'(CH_UART)) ? UART_SKIP : PIO_SKIP;
      iosel_window_cmp #(
         .ADDR_W(ADDR_W),
         .SKIP  (SKIP)
      ) u_cmp (
         .addr(addr),
         .base(cfg_q[g][ADDR_W-1:0]),
         .en  (cfg_q[g][ADDR_W]),
         .qual(io_cycle),
         .hit (hit[g])
      );
   end

   iosel_arbiter #(
      .NUM_CH(NUM_CH)
   ) u_arb (
      .hit  (hit),
      .grant(grant),
      .multi(clash)
   );

   assign tmr_sel_n  = !grant[CH_TMR];
   assign uart_sel_n = !grant[CH_UART];
   assign pio0_sel_n = !grant[CH_PIO0];
   assign pio1_sel_n = !grant[CH_PIO1];

endmodule

// File: rtl/iosel_checker.sv
module iosel_checker #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned UART_SKIP = 2,
   localparam int unsigned NUM_CH = 4,
   localparam int unsigned CFG_W  = ADDR_W + 1,
   localparam int unsigned IDX_W  = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cfg_we,
   input logic [IDX_W-1:0]             cfg_idx,
   input logic [CFG_W-1:0]             cfg_wdata,
   input logic                         iorq_n,
   input logic                         m1_n,
   input logic [ADDR_W-1:0]            addr,
   input logic [NUM_CH-1:0][CFG_W-1:0] cfg_q,
   input logic [NUM_CH-1:0]            sel_n,
   input logic                         clash
);

   AST_TMR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n[0] |-> (addr == cfg_q[0][ADDR_W-1:0])); // R2

   AST_UART_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n[1] |-> (addr[ADDR_W-1:UART_SKIP] == cfg_q[1][ADDR_W-1:UART_SKIP])); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(!iorq_n && m1_n) |-> (&sel_n && !clash)); // R6

   AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[2][ADDR_W] |-> sel_n[2]); // R7

   AST_SINGLE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sel_n)); // R8

   AST_CLASH_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> !(&sel_n)); // R9

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_q[$past(cfg_idx)] == $past(cfg_wdata))); // R5

   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q)); // R10

endmodule

bind iosel_top iosel_checker #(
   .ADDR_W   (ADDR_W),
   .UART_SKIP(UART_SKIP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_idx  (cfg_idx),
   .cfg_wdata(cfg_wdata),
   .iorq_n   (iorq_n),
   .m1_n     (m1_n),
   .addr     (addr),
   .cfg_q    (cfg_q),
   .sel_n    ({pio1_sel_n, pio0_sel_n, uart_sel_n, tmr_sel_n}),
   .clash    (clash)
);

// File: tb/iosel_top_bench.sv
module iosel_top_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_idx = '0;
   logic [8:0] cfg_wdata = '0;
   logic       iorq_n = 1'b1;
   logic       m1_n = 1'b1;
   logic [7:0] addr = '0;
   logic       tmr_sel_n, uart_sel_n, pio0_sel_n, pio1_sel_n, clash;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iosel_top u_iosel_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .iorq_n    (iorq_n),
      .m1_n      (m1_n),
      .addr      (addr),
      .tmr_sel_n (tmr_sel_n),
      .uart_sel_n(uart_sel_n),
      .pio0_sel_n(pio0_sel_n),
      .pio1_sel_n(pio1_sel_n),
      .clash     (clash)
   );

   // Expected select vector is active high: {pio1, pio0, uart, tmr}.
   task automatic expect_sel(input logic [3:0] exp_sel, input logic exp_clash,
                             input string tag);
      logic [3:0] act;
      act = ~{pio1_sel_n, pio0_sel_n, uart_sel_n, tmr_sel_n};
      checks++;
      if (act !== exp_sel || clash !== exp_clash) begin
         fails++;
         $display("FAIL %s: sel=%b clash=%b expected sel=%b clash=%b",
                  tag, act, clash, exp_sel, exp_clash);
      end
   endtask

   // Drive a bus state at the falling edge and sample a quarter period later.
   task automatic bus(input logic io_n, input logic fetch_n, input logic [7:0] a);
      @(negedge clk);
      iorq_n = io_n;
      m1_n   = fetch_n;
      addr   = a;
      #(CLK_PERIOD/4);
   endtask

   task automatic cfg_write(input logic [1:0] idx, input logic en, input logic [7:0] base);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_idx   = idx;
      cfg_wdata = {en, base};
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_map();
      bus(1'b1, 1'b1, 8'h10);
      expect_sel(4'b0000, 1'b0, "R1/R6 idle after reset");
      bus(1'b0, 1'b1, 8'h10);
      expect_sel(4'b0001, 1'b0, "R1/R2 timer default 0x10");
      bus(1'b0, 1'b1, 8'h11);
      expect_sel(4'b0000, 1'b0, "R2 timer compares bit 0");
      bus(1'b0, 1'b1, 8'h90);
      expect_sel(4'b0000, 1'b0, "R2 timer compares bit 7");
      bus(1'b0, 1'b1, 8'h03);
      expect_sel(4'b0010, 1'b0, "R1/R3 uart default window top");
      bus(1'b0, 1'b1, 8'h00);
      expect_sel(4'b0010, 1'b0, "R3 uart window bottom");
      bus(1'b0, 1'b1, 8'h06);
      expect_sel(4'b0100, 1'b0, "R1/R4 pio0 default window");
      bus(1'b0, 1'b1, 8'h0B);
      expect_sel(4'b1000, 1'b0, "R1/R4 pio1 default window");
      bus(1'b0, 1'b1, 8'h0C);
      expect_sel(4'b0000, 1'b0, "R4 just above pio1 window");
   endtask

   task automatic t_qualify();
      bus(1'b0, 1'b0, 8'h10);
      expect_sel(4'b0000, 1'b0, "R6 interrupt acknowledge ignored");
      bus(1'b1, 1'b0, 8'h05);
      expect_sel(4'b0000, 1'b0, "R6 fetch without io request");
      bus(1'b1, 1'b1, 8'h05);
      expect_sel(4'b0000, 1'b0, "R6 no io request");
   endtask

   task automatic t_rewrite();
      cfg_write(2'd1, 1'b1, 8'h40);
      bus(1'b0, 1'b1, 8'h43);
      expect_sel(4'b0010, 1'b0, "R5 uart moved to 0x40");
      bus(1'b0, 1'b1, 8'h01);
      expect_sel(4'b0000, 1'b0, "R5 old uart window gone");
      // Strobe low: the index and data must not land.
      @(negedge clk);
      cfg_idx   = 2'd0;
      cfg_wdata = {1'b1, 8'h55};
      repeat (2) @(negedge clk);
      bus(1'b0, 1'b1, 8'h55);
      expect_sel(4'b0000, 1'b0, "R10 unstrobed data ignored");
      bus(1'b0, 1'b1, 8'h10);
      expect_sel(4'b0001, 1'b0, "R10 timer base kept");
   endtask

   task automatic t_disable();
      cfg_write(2'd0, 1'b0, 8'h10);
      bus(1'b0, 1'b1, 8'h10);
      expect_sel(4'b0000, 1'b0, "R7 disabled timer stays high");
      cfg_write(2'd3, 1'b0, 8'h08);
      bus(1'b0, 1'b1, 8'h09);
      expect_sel(4'b0000, 1'b0, "R7 disabled pio1 stays high");
   endtask

   task automatic t_overlap();
      cfg_write(2'd0, 1'b1, 8'h41);
      bus(1'b0, 1'b1, 8'h41);
      expect_sel(4'b0001, 1'b1, "R8/R9 timer beats uart");
      bus(1'b0, 1'b1, 8'h42);
      expect_sel(4'b0010, 1'b0, "R9 single match no clash");
      cfg_write(2'd2, 1'b1, 8'h40);
      bus(1'b0, 1'b1, 8'h42);
      expect_sel(4'b0010, 1'b1, "R8/R9 uart beats pio0");
      bus(1'b0, 1'b0, 8'h42);
      expect_sel(4'b0000, 1'b0, "R9 no clash outside io cycle");
      cfg_write(2'd1, 1'b0, 8'h40);
      cfg_write(2'd3, 1'b1, 8'h43);
      bus(1'b0, 1'b1, 8'h40);
      expect_sel(4'b0100, 1'b1, "R8/R9 pio0 beats pio1");
      cfg_write(2'd2, 1'b0, 8'h40);
      bus(1'b0, 1'b1, 8'h40);
      expect_sel(4'b1000, 1'b0, "R7/R8 pio1 alone after pio0 off");
   endtask

   task automatic t_reset_again();
      do_reset();
      bus(1'b0, 1'b1, 8'h02);
      expect_sel(4'b0010, 1'b0, "R1 uart default restored");
      bus(1'b0, 1'b1, 8'h41);
      expect_sel(4'b0000, 1'b0, "R1 reprogrammed windows cleared");
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      do_reset();
      t_reset_map();
      t_qualify();
      t_rewrite();
      t_disable();
      t_overlap();
      t_reset_again();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         finish_run();
      end
   end

endmodule